// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transceiver

This block sends and receives asynchronous serial characters of eight data bits. A small framing register chooses whether a parity bit is present, whether that parity is even or odd, and whether the transmitter ends each character with one or two stop bits. The bit clock comes in as a single-cycle enable pulse at sixteen times the bit rate. No baud divider, FIFO or interrupt logic sits inside the block.

The transmitter accepts a byte through a valid/ready handshake. It then drives a low start bit, the data bits least significant first, an optional parity bit and the stop bits, each held for sixteen ticks. The line rests high between characters. The receiver synchronises the incoming line and waits for a high-to-low transition seen on a tick. It confirms the start bit by sampling again eight ticks later, then samples every later bit at its centre. For each character it delivers the byte together with a parity-error flag and a framing-error flag on a one-cycle valid pulse. The receiver looks only at the first stop bit. A low level where a second stop bit would sit therefore counts as the next start bit.

Both halves copy the framing register when a character begins, so a register write never changes a frame already under way.

Transmitter states: TX_IDLE (ready high, line high). TX_IDLE→TX_START on an accepted byte. TX_START→TX_DATA after 16 ticks. TX_DATA→TX_PARITY (parity on) or TX_STOP1 (parity off) after the eighth data bit. TX_PARITY→TX_STOP1. TX_STOP1→TX_STOP2 (two stops) or TX_IDLE. TX_STOP2→TX_IDLE.

Receiver states: RX_IDLE. RX_IDLE→RX_START on a tick-sampled falling edge. RX_START→RX_DATA when the mid-bit confirm sample is low, or back to RX_IDLE when it is high. RX_DATA→RX_PARITY or RX_STOP after eight samples. RX_PARITY→RX_STOP. RX_STOP→RX_IDLE with the result pulse.

Top module: `serial_frame_xcvr`

## Requirements
- R1: After reset the transmit line is high, the transmitter is ready, the framing register reads 0 (parity off, even, one stop bit) and no receive result is signalled.
- R2: An accepted byte is sent as one low start bit, then the 8 data bits least significant first, then stop bits at level 1. Every bit lasts 16 ticks. Ready stays low from acceptance until the last stop bit has ended.
- R3: With parity enabled (register bit 3 = 1), a parity bit follows the data. Register bit 2 = 0 makes the count of ones over data plus parity even. Bit 2 = 1 makes it odd.
- R4: With parity disabled, no parity bit is sent, the receiver expects none, the parity-error flag stays 0, and register bit 2 has no effect on either direction.
- R5: Register bit 1 = 1 makes the transmitter send two stop bits. Bit 1 = 0 makes it send one.
- R6: The receiver rebuilds each 8-bit character and presents it on a one-cycle valid pulse.
- R7: With parity enabled, a received parity bit that breaks the selected sense sets the parity-error flag for that character.
- R8: A first stop bit sampled low sets the framing-error flag for that character.
- R9: The receiver checks only the first stop bit, whatever register bit 1 holds. A low level right after the first stop bit is taken as the start of the next character, with no error.
- R10: Register bit 0 is reserved. It always reads 0, and writes to it are dropped. Bits 3..1 read back as written.
- R11: A register write during a character does not change that character's framing. The new setting applies from the next character.
- R12: A low pulse on the receive line shorter than half a bit, ending before the mid-bit confirm sample, produces no received character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16× the bit rate |
| mode_we | input | 1 | Framing register write strobe |
| mode_wdata | input | 4 | Write data: [3] parity on, [2] odd, [1] two stops, [0] reserved |
| mode_rdata | output | 4 | Framing register read value, bit 0 always 0 |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_valid | output | 1 | One-cycle pulse: a received character is presented |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity mismatch on this character |
| rx_frame_err | output | 1 | First stop bit was low on this character |

## Verification
The bench keeps its own model of the serial line, based on counting ticks, and compares it with the transmit line and ready on every clock. A parity sense that is inverted, a bit order that is reversed, a missing second stop bit or a frame that runs one tick long or short therefore shows up as a level mismatch at a known tick. Parity-error and framing-error frames are driven by hand to check that each flag reaches the right character. A receiver that enforced the second stop bit would either flag a false framing error or lose the character that follows it. A start-bit glitch shorter than half a bit is sent to catch a receiver that skips the mid-bit confirm, which would output a spurious character. A register write during a frame and odd parity with parity disabled show whether framing was latched at the start of the frame and whether the parity sense is properly gated.

// File: rtl/frame_xcvr_pkg.sv
package frame_xcvr_pkg;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_mode_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP1,
        TX_STOP2
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

endpackage

// File: rtl/frame_mode_reg.sv
module frame_mode_reg
    import frame_xcvr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [3:0]  wdata,
    output frame_mode_t mode,
    output logic [3:0]  rdata
);

    logic unused_rsvd_bit;
    assign unused_rsvd_bit = wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (we) begin
            mode <= '{par_en: wdata[3], par_odd: wdata[2], two_stop: wdata[1]};
        end
    end

    assign rdata = {mode.par_en, mode.par_odd, mode.two_stop, 1'b0};

    // R10
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == {$past(wdata[3:1]), 1'b0}));

endmodule

// File: rtl/frame_tx.sv
module frame_tx
    import frame_xcvr_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  frame_mode_t          mode,
    input  logic                 in_valid,
    input  logic [DATA_BITS-1:0] in_data,
    output logic                 in_ready,
    output logic                 line
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_BITS);

    tx_state_t              state, state_nx;
    logic [CNT_W-1:0]       cnt;
    logic [IDX_W-1:0]       bit_idx;
    logic [DATA_BITS-1:0]   shreg;
    logic                   par_bit;
    frame_mode_t            mode_q;
    logic                   bit_end;

    assign bit_end = tick && (cnt == CNT_W'(OVERSAMPLE - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:   if (in_valid) state_nx = TX_START;
            TX_START:  if (bit_end) state_nx = TX_DATA;
            TX_DATA:   if (bit_end && bit_idx == IDX_W'(DATA_BITS - 1))
                           state_nx = mode_q.par_en ? TX_PARITY : TX_STOP1;
            TX_PARITY: if (bit_end) state_nx = TX_STOP1;
            TX_STOP1:  if (bit_end) state_nx = mode_q.two_stop ? TX_STOP2 : TX_IDLE;
            TX_STOP2:  if (bit_end) state_nx = TX_IDLE;
            default:   state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            mode_q  <= '0;
        end else begin
            state <= state_nx;
            if (state == TX_IDLE) begin
                if (in_valid) begin
                    shreg   <= in_data;
                    mode_q  <= mode;
                    par_bit <= (^in_data) ^ mode.par_odd;
                    cnt     <= '0;
                    bit_idx <= '0;
                end
            end else if (tick) begin
                cnt <= bit_end ? '0 : cnt + 1'b1;
                if (bit_end && state == TX_DATA) begin
                    shreg   <= {1'b0, shreg[DATA_BITS-1:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        in_ready = 1'b0;
        line     = 1'b1;
        unique case (state)
            TX_IDLE:   in_ready = 1'b1;
            TX_START:  line = 1'b0;
            TX_DATA:   line = shreg[0];
            TX_PARITY: line = par_bit;
            TX_STOP1, TX_STOP2: line = 1'b1;
            default:   line = 1'b1;
        endcase
    end

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!line && !in_ready));

    // R2
    ready_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> line);

endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import frame_xcvr_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 line_in,
    output logic                 out_valid,
    output logic [DATA_BITS-1:0] out_data,
    output logic                 out_perr,
    output logic                 out_ferr
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam int HALF  = OVERSAMPLE / 2;

    rx_state_t             state, state_nx;
    logic                  sync1, sync2, prev_lvl;
    logic [CNT_W-1:0]      cnt;
    logic [IDX_W-1:0]      bit_idx;
    logic [DATA_BITS-1:0]  shreg;
    logic                  acc, perr_q;
    logic                  en_q, odd_q;
    logic                  fall, samp, confirm;

    assign fall    = tick && prev_lvl && !sync2;
    assign samp    = tick && (cnt == CNT_W'(OVERSAMPLE - 1));
    assign confirm = tick && (cnt == CNT_W'(HALF - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (fall) state_nx = RX_START;
            RX_START:  if (confirm) state_nx = sync2 ? RX_IDLE : RX_DATA;
            RX_DATA:   if (samp && bit_idx == IDX_W'(DATA_BITS - 1))
                           state_nx = en_q ? RX_PARITY : RX_STOP;
            RX_PARITY: if (samp) state_nx = RX_STOP;
            RX_STOP:   if (samp) state_nx = RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1    <= 1'b1;
            sync2    <= 1'b1;
            prev_lvl <= 1'b1;
            state    <= RX_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            acc      <= 1'b0;
            perr_q   <= 1'b0;
            en_q     <= 1'b0;
            odd_q    <= 1'b0;
        end else begin
            sync1 <= line_in;
            sync2 <= sync1;
            if (tick) prev_lvl <= sync2;
            state <= state_nx;
            unique case (state)
                RX_IDLE: if (fall) begin
                    cnt     <= '0;
                    bit_idx <= '0;
                    acc     <= 1'b0;
                    perr_q  <= 1'b0;
                    en_q    <= par_en;
                    odd_q   <= par_odd;
                end
                RX_START: if (tick) cnt <= confirm ? '0 : cnt + 1'b1;
                default: if (tick) begin
                    cnt <= samp ? '0 : cnt + 1'b1;
                    if (samp && state == RX_DATA) begin
                        shreg   <= {sync2, shreg[DATA_BITS-1:1]};
                        acc     <= acc ^ sync2;
                        bit_idx <= bit_idx + 1'b1;
                    end
                    if (samp && state == RX_PARITY)
                        perr_q <= acc ^ sync2 ^ odd_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_perr  <= 1'b0;
            out_ferr  <= 1'b0;
        end else begin
            out_valid <= (state == RX_STOP) && samp;
            if ((state == RX_STOP) && samp) begin
                out_data <= shreg;
                out_perr <= perr_q;
                out_ferr <= !sync2;
            end
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4
    no_perr_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !en_q) |-> !out_perr);

endmodule

// File: rtl/serial_frame_xcvr.sv
module serial_frame_xcvr
    import frame_xcvr_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 mode_we,
    input  logic [3:0]           mode_wdata,
    output logic [3:0]           mode_rdata,
    input  logic                 tx_valid,
    input  logic [DATA_BITS-1:0] tx_data,
    output logic                 tx_ready,
    output logic                 tx_line,
    input  logic                 rx_line,
    output logic                 rx_valid,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_parity_err,
    output logic                 rx_frame_err
);

    frame_mode_t mode;

    frame_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode_we),
        .wdata (mode_wdata),
        .mode  (mode),
        .rdata (mode_rdata)
    );

    frame_tx #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .mode     (mode),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .in_ready (tx_ready),
        .line     (tx_line)
    );

    frame_rx #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .par_en    (mode.par_en),
        .par_odd   (mode.par_odd),
        .line_in   (rx_line),
        .out_valid (rx_valid),
        .out_data  (rx_data),
        .out_perr  (rx_parity_err),
        .out_ferr  (rx_frame_err)
    );

endmodule

// File: tb/test_serial_frame_xcvr.sv
`timescale 1ns/1ps
module test_serial_frame_xcvr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       mode_we = 1'b0;
    logic [3:0] mode_wdata = '0;
    logic [3:0] mode_rdata;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready, tx_line;
    logic       rx_line;
    logic       rx_valid, rx_parity_err, rx_frame_err;
    logic [7:0] rx_data;
    logic       sel_loop = 1'b1;
    logic       drv_line = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int tcnt   = 0;

    always #10 clk = ~clk;

    assign rx_line = sel_loop ? tx_line : drv_line;

    serial_frame_xcvr i_serial_frame_xcvr (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_line(tx_line),
        .rx_line(rx_line), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
    );

    // tick every 4 clocks, driven away from the sampling edge
    always @(negedge clk) begin
        tcnt   <= (tcnt + 1) % 4;
        tick16 <= (tcnt == 3);
    end

    function automatic logic [15:0] fbits(input logic [7:0] d, input bit pe,
                                          input bit odd, input bit flip, input bit s1);
        logic [15:0] b;
        b = 16'hFFFF;
        b[0] = 1'b0;
        for (int i = 0; i < 8; i++) b[1+i] = d[i];
        if (pe) begin
            b[9]  = (^d) ^ odd ^ flip;
            b[10] = s1;
        end else begin
            b[9] = s1;
        end
        return b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural transmit model: framing, line level, ready
    logic        m_pe = 0, m_odd = 0, m_two = 0;
    logic        m_act = 0;
    logic [15:0] m_bits = '1;
    int          m_len = 0;
    int          m_n = 0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mode_we) begin
                m_pe  <= mode_wdata[3];
                m_odd <= mode_wdata[2];
                m_two <= mode_wdata[1];
            end
            if (!m_act && tx_valid) begin
                m_act  <= 1'b1;
                m_n    <= 0;
                m_bits <= fbits(tx_data, m_pe, m_odd, 1'b0, 1'b1);
                m_len  <= 10 + int'(m_pe) + int'(m_two);
            end else if (m_act && tick16) begin
                m_n <= m_n + 1;
                if (m_n + 1 == 16 * m_len) m_act <= 1'b0;
            end
        end
    end

    logic [9:0] rxq[$];

    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_line;
            exp_line = m_act ? m_bits[m_n / 16] : 1'b1;
            // R2 R3 R4 R5 R11: line level per tick position
            check(tx_line == exp_line, "R2,R3,R4,R5,R11 tx_line", tx_line, exp_line);
            check(tx_ready == !m_act, "R2 tx_ready", tx_ready, !m_act);
            if (rx_valid) begin
                if (rxq.size() == 0) begin
                    check(1'b0, "R6,R12 unexpected rx_valid", rx_data, 0);
                end else begin
                    logic [9:0] e;
                    e = rxq.pop_front();
                    // R6 R7 R8 R9 R4
                    check({rx_data, rx_parity_err, rx_frame_err} == e,
                          "R6,R7,R8,R9 rx result", {rx_data, rx_parity_err, rx_frame_err}, e);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wait_ticks(input int k);
        repeat (k) begin
            @(posedge clk);
            while (!tick16) @(posedge clk);
        end
    endtask

    task automatic wr_mode(input logic [3:0] v);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = v;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic send_tx(input logic [7:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_valid = 1'b1;
        tx_data = d;
        rxq.push_back({d, 2'b00});
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic tx_drain();
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        wait_ticks(24);
    endtask

    task automatic drive(input logic [15:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            drv_line <= b[i];
            wait_ticks(16);
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(tx_line == 1'b1, "R1 tx_line", tx_line, 1);
        check(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
        check(mode_rdata == 4'h0, "R1 mode_rdata", mode_rdata, 0);
        check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        rst_n = 1'b1;

        // R10: reserved bit
        wr_mode(4'b0001);
        check(mode_rdata == 4'b0000, "R10 reserved only", mode_rdata, 0);
        wr_mode(4'b1111);
        check(mode_rdata == 4'b1110, "R10 all bits", mode_rdata, 4'b1110);

        // R2 R6: plain 8N1 loopback
        wr_mode(4'b0000);
        send_tx(8'hA5);
        send_tx(8'h3C);
        tx_drain();
        // R3: even then odd parity
        wr_mode(4'b1000);
        send_tx(8'h07);
        send_tx(8'h81);
        tx_drain();
        wr_mode(4'b1100);
        send_tx(8'h07);
        send_tx(8'h00);
        tx_drain();
        // R4: odd selected but parity off
        wr_mode(4'b0100);
        send_tx(8'h5A);
        tx_drain();
        // R5: two stop bits, back to back
        wr_mode(4'b0010);
        send_tx(8'hF0);
        send_tx(8'h0F);
        tx_drain();
        // R11: register change mid-frame
        wr_mode(4'b1000);
        send_tx(8'h33);
        wait_ticks(40);
        wr_mode(4'b0010);
        tx_drain();
        check(rxq.size() == 0, "R6 loopback all received", rxq.size(), 0);

        // receive-side cases driven directly
        drv_line <= 1'b1;
        sel_loop = 1'b0;
        wait_ticks(20);
        // R7: good and bad even parity
        wr_mode(4'b1000);
        rxq.push_back({8'h96, 2'b00});
        drive(fbits(8'h96, 1, 0, 0, 1), 11);
        rxq.push_back({8'h96, 2'b10});
        drive(fbits(8'h96, 1, 0, 1, 1), 11);
        wait_ticks(16);
        // R8: low first stop bit
        wr_mode(4'b0000);
        rxq.push_back({8'hC3, 2'b01});
        drive(fbits(8'hC3, 0, 0, 0, 0), 10);
        drv_line <= 1'b1;
        wait_ticks(40);
        // R9: two-stop setting, next start right after first stop
        wr_mode(4'b0010);
        rxq.push_back({8'h11, 2'b00});
        rxq.push_back({8'h22, 2'b00});
        drive(fbits(8'h11, 0, 0, 0, 1), 10);
        drive(fbits(8'h22, 0, 0, 0, 1), 11);
        wait_ticks(16);
        // R12: short start glitch
        drv_line <= 1'b0;
        wait_ticks(3);
        drv_line <= 1'b1;
        wait_ticks(48);
        check(rxq.size() == 0, "R9,R12 queue drained", rxq.size(), 0);
        // R4: receive with odd set but parity off
        wr_mode(4'b0100);
        rxq.push_back({8'h5A, 2'b00});
        drive(fbits(8'h5A, 0, 0, 0, 1), 11);
        wait_ticks(16);
        check(rxq.size() == 0, "R4,R6 all results seen", rxq.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule